// File: doc/BRIEF.md
# Instruction-Driven Serial Register Port

This block is the slave side of a single-wire, bidirectional, synchronous serial link. It samples the serial clock, the optional active-low select and the data pin in the system-clock domain. Every transaction opens with an 8-bit instruction that sets the direction, a byte count and a 4-bit start address. After the instruction, the block moves the requested number of bytes between the pin and an external byte-wide register port.

The address map has a 24-bit data word, a 16-bit command word and two 24-bit calibration words. The holes in that map are decoded inside the block: they read as zero and they drop any write. Two configuration inputs come from the command word kept outside the block. One selects walking the address downwards instead of upwards. The other selects sending the bits of each data byte low bit first. The block also controls the enable of the pin's tri-state driver, with fixed turn-on and turn-off delays, and it abandons a transfer that stalls for too long.

Top module: `serial_regif`

## Requirements
- R1: An instruction is 8 bits, always sent high bit first. Bit 7 = 1 selects a read and 0 a write. Bits 6:5 give the byte count: 00 is 1, 01 is 2, 10 is 3, and 11 is also treated as 3. Bit 4 is ignored. Bits 3:0 give the start address.
- R2: Each data bit is sampled on a falling serial-clock edge. Each completed write byte produces exactly one single-cycle `reg_we_o` pulse, with that byte's address on `reg_addr_o` and the byte on `reg_wdata_o`.
- R3: After each byte the address moves up by one, or down by one when `byte_rev_i` = 1. The address wraps modulo 16.
- R4: A write whose current address is 4 or 5 (the command word) always moves the address upward, whatever `byte_rev_i` says.
- R5: With `lsb_first_i` = 0, data bits travel high bit first. With `lsb_first_i` = 1 they travel low bit first. This applies to both reads and writes.
- R6: A read byte is taken from `reg_rdata_i` at the current address. Each bit is updated after a rising serial-clock edge and held until the following falling edge. Reserved addresses (3, 6, 7, 11, 15) read as 0x00.
- R7: A write to a reserved address produces no `reg_we_o` pulse.
- R8: For a read, `sdio_oe_o` rises 8 to 10 system clocks after the falling edge that ends the instruction. It falls 4 to 6 system clocks after the last falling edge of the read data. It stays low during writes.
- R9: While `cs_ni` is high, serial-clock edges are ignored. Raising `cs_ni` does not turn off the driver during a read.
- R10: When no qualified serial-clock edge arrives for `TIMEOUT_CYC` system clocks during an unfinished transfer, the transfer is dropped. The driver turns off, no partial byte is written, and the next edge starts a new instruction.
- R11: After reset, `sdio_oe_o` and `reg_we_o` are low and the block waits for an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Active-low select; tie low if unused |
| sdio_i | input | 1 | Serial data from the pin |
| sdio_o | output | 1 | Serial data to the pin driver |
| sdio_oe_o | output | 1 | Pin driver enable |
| byte_rev_i | input | 1 | 1: address moves downward after each byte |
| lsb_first_i | input | 1 | 1: data bits travel low bit first |
| reg_addr_o | output | 4 | Register byte address |
| reg_we_o | output | 1 | Single-cycle write strobe |
| reg_wdata_o | output | 8 | Write byte |
| reg_rdata_i | input | 8 | Read byte at `reg_addr_o` |

## Verification
The bench targets several corner cases, and each one exposes a specific design error:
- An address wrap from 15 to 0 that passes through a reserved slot. A design that wraps wrongly, or that writes the hole, corrupts byte 0 or the hole.
- A command-word write with the downward direction selected. A design that obeys the direction bit here lands the second byte on address 3.
- A low-bit-first byte chosen so that a reversed shift gives a different value.
- Driver turn-on and turn-off counted in system clocks. An off-by-one delay falls outside the window.
- Clock activity while deselected. A design that listens anyway desynchronises the next instruction.
- A stall in the middle of a byte, and a stall with the driver on. A design with no working timeout corrupts the next transfer or keeps driving.

// File: rtl/serial_regif_pkg.sv
`timescale 1ns/1ps
package serial_regif_pkg;
  localparam int ADDR_W = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_INSTR,
    ST_WR,
    ST_RD_WAIT,
    ST_RD,
    ST_RD_OFF
  } sif_state_e;

  // holes in the map: 3, 6, 7, 11, 15
  function automatic logic addr_reserved(input logic [ADDR_W-1:0] a);
    return (a[1:0] == 2'b11) || (a == 4'd6);
  endfunction

  function automatic logic addr_is_cmd(input logic [ADDR_W-1:0] a);
    return (a == 4'd4) || (a == 4'd5);
  endfunction

  function automatic logic [1:0] nbytes_m1(input logic [1:0] mb);
    return (mb == 2'b11) ? 2'd2 : mb;
  endfunction

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a, input logic dec);
    return dec ? a - 4'd1 : a + 4'd1;
  endfunction
endpackage

// File: rtl/serial_regif_sync.sv
`timescale 1ns/1ps
module serial_regif_sync #(
  parameter int             STAGES  = 2,
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= RST_VAL;
      else if (g == 0) stage_q[g] <= d_i;
      else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/serial_regif_timer.sv
`timescale 1ns/1ps
module serial_regif_timer #(
  parameter int LIMIT = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic kick_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i || kick_i) cnt_q <= '0;
    else if (cnt_q != LIMIT_C) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && !kick_i && (cnt_q == LIMIT_C);
endmodule

// File: rtl/serial_regif.sv
`timescale 1ns/1ps
module serial_regif
  import serial_regif_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int OE_ON_CYC   = 9,
  parameter int OE_OFF_CYC  = 5,
  parameter int TIMEOUT_CYC = 250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  input  logic              byte_rev_i,
  input  logic              lsb_first_i,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_we_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  // edge seen SYNC_STAGES+1 cycles after the pin, acted on one later
  localparam int ON_WAIT  = OE_ON_CYC  - SYNC_STAGES - 2;
  localparam int OFF_WAIT = OE_OFF_CYC - SYNC_STAGES - 2;
  localparam int DLY_MAX  = (ON_WAIT > OFF_WAIT) ? ON_WAIT : OFF_WAIT;
  localparam int DLY_W    = (DLY_MAX < 2) ? 1 : $clog2(DLY_MAX + 1);

  logic [2:0] sync_q;
  logic       sclk_s, sdio_s, cs_s, sclk_d;
  logic       rise_ok, fall_ok, idle_expire, tmr_run;

  sif_state_e        state_q;
  logic [2:0]        bit_cnt_q;
  logic [1:0]        left_q;
  logic [ADDR_W-1:0] addr_q, waddr_q;
  logic [BYTE_W-1:0] sh_q, wdata_q, rd_byte_q;
  logic [DLY_W-1:0]  dly_q;
  logic              oe_q, out_q, we_q;

  logic [BYTE_W-1:0] instr_nxt, data_nxt, rd_now;
  logic              dec;

  serial_regif_sync #(
    .STAGES (SYNC_STAGES),
    .W      (3),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sdio_i, sclk_i}),
    .q_o   (sync_q)
  );
  assign {cs_s, sdio_s, sclk_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else sclk_d <= sclk_s;
  end

  assign rise_ok = !sclk_d &&  sclk_s && !cs_s;
  assign fall_ok =  sclk_d && !sclk_s && !cs_s;

  assign tmr_run = (state_q != ST_INSTR) || (bit_cnt_q != 3'd0);

  serial_regif_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (tmr_run),
    .kick_i  (rise_ok || fall_ok),
    .expire_o(idle_expire)
  );

  assign instr_nxt = {sh_q[BYTE_W-2:0], sdio_s};
  assign data_nxt  = lsb_first_i ? {sdio_s, sh_q[BYTE_W-1:1]} : instr_nxt;
  assign rd_now    = addr_reserved(addr_q) ? '0 : reg_rdata_i;
  // command word writes always walk upward
  assign dec       = byte_rev_i && !((state_q == ST_WR) && addr_is_cmd(addr_q));

  function automatic logic pick(input logic [BYTE_W-1:0] b, input logic [2:0] i, input logic lsbf);
    return lsbf ? b[i] : b[3'd7 - i];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_INSTR;
      bit_cnt_q <= '0;
      left_q    <= '0;
      addr_q    <= '0;
      waddr_q   <= '0;
      sh_q      <= '0;
      wdata_q   <= '0;
      rd_byte_q <= '0;
      dly_q     <= '0;
      oe_q      <= 1'b0;
      out_q     <= 1'b0;
      we_q      <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (idle_expire) begin
        state_q   <= ST_INSTR;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
      end else begin
        unique case (state_q)
          ST_INSTR: if (fall_ok) begin
            sh_q      <= instr_nxt;
            bit_cnt_q <= bit_cnt_q + 3'd1;
            if (bit_cnt_q == 3'd7) begin
              addr_q <= instr_nxt[ADDR_W-1:0];
              left_q <= nbytes_m1(instr_nxt[6:5]);
              if (instr_nxt[7]) begin
                state_q <= ST_RD_WAIT;
                dly_q   <= DLY_W'(ON_WAIT);
              end else begin
                state_q <= ST_WR;
              end
            end
          end
          ST_WR: if (fall_ok) begin
            sh_q      <= data_nxt;
            bit_cnt_q <= bit_cnt_q + 3'd1;
            if (bit_cnt_q == 3'd7) begin
              we_q    <= !addr_reserved(addr_q);
              waddr_q <= addr_q;
              wdata_q <= data_nxt;
              addr_q  <= step_addr(addr_q, dec);
              if (left_q == 2'd0) state_q <= ST_INSTR;
              else left_q <= left_q - 2'd1;
            end
          end
          ST_RD_WAIT: begin
            if (dly_q == '0) begin
              oe_q    <= 1'b1;
              state_q <= ST_RD;
            end else begin
              dly_q <= dly_q - 1'b1;
            end
          end
          ST_RD: begin
            if (rise_ok) begin
              if (bit_cnt_q == 3'd0) begin
                rd_byte_q <= rd_now;
                out_q     <= pick(rd_now, 3'd0, lsb_first_i);
              end else begin
                out_q <= pick(rd_byte_q, bit_cnt_q, lsb_first_i);
              end
            end
            if (fall_ok) begin
              bit_cnt_q <= bit_cnt_q + 3'd1;
              if (bit_cnt_q == 3'd7) begin
                addr_q <= step_addr(addr_q, dec);
                if (left_q == 2'd0) begin
                  state_q <= ST_RD_OFF;
                  dly_q   <= DLY_W'(OFF_WAIT);
                end else begin
                  left_q <= left_q - 2'd1;
                end
              end
            end
          end
          ST_RD_OFF: begin
            if (dly_q == '0) begin
              oe_q    <= 1'b0;
              state_q <= ST_INSTR;
            end else begin
              dly_q <= dly_q - 1'b1;
            end
          end
          default: state_q <= ST_INSTR;
        endcase
      end
    end
  end

  assign sdio_o      = out_q;
  assign sdio_oe_o   = oe_q;
  assign reg_we_o    = we_q;
  assign reg_wdata_o = wdata_q;
  assign reg_addr_o  = we_q ? waddr_q : addr_q;
endmodule

// File: rtl/serial_regif_chk.sv
`timescale 1ns/1ps
module serial_regif_chk
  import serial_regif_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_o,
  input logic [ADDR_W-1:0] reg_addr_o,
  input logic              sdio_oe_o,
  input logic              cs_s,
  input logic              idle_expire,
  input sif_state_e        state_q
);
  // R7
  reserved_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> !addr_reserved(reg_addr_o));

  // R2
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  // R8
  oe_write_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> !sdio_oe_o);

  // R8
  oe_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdio_oe_o) |-> $past(state_q) == ST_RD_WAIT);

  // R9
  cs_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> !reg_we_o);

  // R10
  timeout_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_expire |=> (state_q == ST_INSTR) && !sdio_oe_o && !reg_we_o);
endmodule

bind serial_regif serial_regif_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_o   (reg_we_o),
  .reg_addr_o (reg_addr_o),
  .sdio_oe_o  (sdio_oe_o),
  .cs_s       (cs_s),
  .idle_expire(idle_expire),
  .state_q    (state_q)
);

// File: tb/serial_regif_tb_top.sv
`timescale 1ns/1ps
module serial_regif_tb_top;
  localparam int H  = 8;
  localparam int TO = 600;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk_i = 1'b0, cs_ni = 1'b0, sdio_i = 1'b0;
  logic byte_rev = 1'b0, lsb_first = 1'b0;
  logic sdio_o, sdio_oe;
  logic [3:0] reg_addr;
  logic reg_we;
  logic [7:0] reg_wdata, reg_rdata;

  logic [7:0] mem [16];
  int wr_cnt = 0, tests = 0, fails = 0;
  logic [7:0] rb [3];
  int on_lat, off_lat;
  logic oe_in_cs;

  always #2.5 clk = ~clk;

  serial_regif #(.TIMEOUT_CYC(TO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk_i), .cs_ni(cs_ni), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe), .byte_rev_i(byte_rev), .lsb_first_i(lsb_first),
    .reg_addr_o(reg_addr), .reg_we_o(reg_we), .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];

  always @(negedge clk) if (reg_we) begin
    mem[reg_addr] = reg_wdata;
    wr_cnt++;
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input string what, input int act, input int lo, input int hi);
    tests++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic clk_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_tx(input logic b);
    @(negedge clk);
    sdio_i = b;
    sclk_i = 1'b1;
    clk_n(H);
    sclk_i = 1'b0;
    clk_n(H);
  endtask

  task automatic byte_tx(input logic [7:0] v, input bit lsbf);
    for (int i = 0; i < 8; i++) bit_tx(lsbf ? v[i] : v[7-i]);
  endtask

  task automatic rd_txn(input logic [7:0] instr, input int nb, input bit lsbf, input bit cs_pulse);
    int n;
    for (int i = 0; i < 7; i++) bit_tx(instr[7-i]);
    @(negedge clk);
    sdio_i = instr[0];
    sclk_i = 1'b1;
    clk_n(H);
    sclk_i = 1'b0;
    n = 0;
    while (!sdio_oe && n < 40) begin @(negedge clk); n++; end
    on_lat = n;
    clk_n(14);
    if (cs_pulse) begin
      cs_ni = 1'b1;
      clk_n(20);
      oe_in_cs = sdio_oe;
      cs_ni = 1'b0;
      clk_n(5);
    end
    for (int k = 0; k < nb; k++) begin
      logic [7:0] v;
      v = '0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        sclk_i = 1'b1;
        clk_n(H);
        if (lsbf) v[i] = sdio_o; else v[7-i] = sdio_o;
        sclk_i = 1'b0;
        if (k == nb-1 && i == 7) begin
          n = 0;
          while (sdio_oe && n < 40) begin @(negedge clk); n++; end
          off_lat = n;
        end else begin
          clk_n(H);
        end
      end
      rb[k] = v;
    end
    clk_n(10);
  endtask

  task automatic t_reset();
    chk("R11", "oe after reset", int'(sdio_oe), 0);
    chk("R11", "we after reset", int'(reg_we), 0);
  endtask

  task automatic t_write_inc();
    int w0 = wr_cnt;
    byte_rev = 0; lsb_first = 0;
    byte_tx(8'h40, 0); byte_tx(8'hA1, 0); byte_tx(8'hB2, 0); byte_tx(8'hC3, 0);
    clk_n(10);
    chk("R1", "3-byte write count", wr_cnt - w0, 3);
    chk("R2", "mem0", mem[0], 8'hA1);
    chk("R3", "mem1", mem[1], 8'hB2);
    chk("R3", "mem2", mem[2], 8'hC3);
  endtask

  task automatic t_read_back();
    rd_txn(8'hC0, 3, 0, 0);
    chk("R6", "rd byte0", rb[0], 8'hA1);
    chk("R6", "rd byte1", rb[1], 8'hB2);
    chk("R6", "rd byte2", rb[2], 8'hC3);
    chk_rng("R8", "oe on latency", on_lat, 8, 10);
    chk_rng("R8", "oe off latency", off_lat, 4, 6);
  endtask

  task automatic t_write_dec();
    byte_rev = 1;
    byte_tx(8'h2A, 0); byte_tx(8'h11, 0); byte_tx(8'h22, 0);
    clk_n(10);
    chk("R3", "dec mem10", mem[10], 8'h11);
    chk("R3", "dec mem9", mem[9], 8'h22);
    rd_txn(8'hAA, 2, 0, 0);
    chk("R3", "dec read first", rb[0], 8'h11);
    chk("R3", "dec read second", rb[1], 8'h22);
    byte_rev = 0;
  endtask

  task automatic t_cmd_write();
    int w0 = wr_cnt;
    byte_rev = 1;
    byte_tx(8'h24, 0); byte_tx(8'h5C, 0); byte_tx(8'h3E, 0);
    clk_n(10);
    chk("R4", "cmd mem4", mem[4], 8'h5C);
    chk("R4", "cmd mem5", mem[5], 8'h3E);
    chk("R4", "cmd write count", wr_cnt - w0, 2);
    byte_rev = 0;
  endtask

  task automatic t_lsb_first();
    lsb_first = 1;
    byte_tx(8'h08, 0); byte_tx(8'h1E, 1);
    clk_n(10);
    chk("R5", "lsb-first write mem8", mem[8], 8'h1E);
    rd_txn(8'h88, 1, 1, 0);
    chk("R5", "lsb-first read", rb[0], 8'h1E);
    lsb_first = 0;
  endtask

  task automatic t_reserved();
    int w0 = wr_cnt;
    byte_tx(8'h03, 0); byte_tx(8'hEE, 0);
    clk_n(10);
    chk("R7", "reserved write strobes", wr_cnt - w0, 0);
    chk("R7", "reserved mem3 kept", mem[3], 8'h77);
    rd_txn(8'h83, 1, 0, 0);
    chk("R6", "reserved read zero", rb[0], 8'h00);
  endtask

  task automatic t_wrap();
    int w0 = wr_cnt;
    byte_tx(8'h2F, 0); byte_tx(8'h99, 0); byte_tx(8'h42, 0);
    clk_n(10);
    chk("R3", "wrap to addr0", mem[0], 8'h42);
    chk("R3", "wrap write count", wr_cnt - w0, 1);
  endtask

  task automatic t_mb3();
    int w0 = wr_cnt;
    byte_tx(8'h6C, 0); byte_tx(8'hD1, 0); byte_tx(8'hD2, 0); byte_tx(8'hD3, 0);
    clk_n(10);
    chk("R1", "count code 11 writes", wr_cnt - w0, 3);
    chk("R1", "mem14", mem[14], 8'hD3);
  endtask

  task automatic t_cs();
    int w0 = wr_cnt;
    cs_ni = 1;
    byte_tx(8'h01, 0); byte_tx(8'hFF, 0);
    cs_ni = 0;
    clk_n(10);
    chk("R9", "deselected writes", wr_cnt - w0, 0);
    byte_tx(8'h01, 0); byte_tx(8'h5D, 0);
    clk_n(10);
    chk("R9", "write after deselect mem1", mem[1], 8'h5D);
    rd_txn(8'h01 | 8'h80, 1, 0, 1);
    chk("R9", "oe held while cs high", int'(oe_in_cs), 1);
    chk("R9", "read after cs pulse", rb[0], 8'h5D);
  endtask

  task automatic t_timeout();
    int w0 = wr_cnt;
    byte_tx(8'h01, 0);
    for (int i = 0; i < 4; i++) bit_tx(1'b0);
    clk_n(TO + 100);
    chk("R10", "stalled write count", wr_cnt - w0, 0);
    byte_tx(8'h02, 0); byte_tx(8'h3C, 0);
    clk_n(10);
    chk("R10", "fresh write mem2", mem[2], 8'h3C);
    chk("R10", "mem1 untouched", mem[1], 8'h5D);
    byte_tx(8'h80, 0);
    clk_n(20);
    chk("R8", "oe on for read", int'(sdio_oe), 1);
    clk_n(TO + 100);
    chk("R10", "oe off after stall", int'(sdio_oe), 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    mem[3] = 8'h77;
    clk_n(4);
    t_reset();
    rst_n = 1'b1;
    clk_n(4);
    t_reset();
    t_write_inc();
    t_read_back();
    t_write_dec();
    t_cmd_write();
    t_lsb_first();
    t_reserved();
    t_wrap();
    t_mb3();
    t_cs();
    t_timeout();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end
endmodule